// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Decimal Mode

This block is the arithmetic and logic datapath of a small eight-bit processor core. Each cycle it can accept one operation: an operation code, an accumulator operand, a memory operand, an auxiliary index operand, a carry input and a decimal-mode input. One clock edge later it presents the eight-bit result, the negative, overflow, zero and carry flags, and a four-bit update mask. The mask tells the surrounding core which of its status flags should take the new value. Flags that the mask does not mark are driven low.

Add and subtract always fold in the carry input. For subtract, the carry acts as an inverted borrow. When decimal mode is set, add and subtract treat both operands as two packed BCD digits. Compare and the combined AND-then-subtract operation always work in binary, whatever the decimal input says. The overflow flag is only ever marked for update by add, subtract and bit test. Instruction decode, register storage and memory access are left to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered with a latency of one clock. `res_valid_o` equals `in_valid_i` from the previous edge, and the other outputs hold their values while `in_valid_i` is low. An active-low reset clears every output to zero.
- R2: Code 0 (add): the result is acc + mem + carry_i modulo 256, and C is the carry out of bit 7. V is set when the signed sum lies outside -128..+127; for example 0x7F+0x01 gives V=1 and 0x81+0xFF gives V=0, both with carry_i clear. N and Z are taken from the result.
- R3: Code 1 (subtract): the result is acc - mem - (1 - carry_i) modulo 256. C=1 means no borrow occurred, and V is the signed overflow of that difference. N and Z are taken from the result.
- R4: Code 0 with dec_i=1: the operands are read as two BCD digits each. The result is the two-digit BCD sum, and C is set when the decimal sum reaches 100. N and Z come from the BCD result, and V is computed as in binary mode.
- R5: Code 1 with dec_i=1: the result is the BCD difference modulo 100. C is cleared when a decimal borrow leaves the high digit. N and Z come from the result, and V is computed as in binary mode.
- R6: Codes 2, 3, 4 and 14 (AND, OR, XOR, load of mem): the result is the logic value or mem, and only N and Z are marked.
- R7: Code 5 (compare): the result is acc, unchanged. C=1 when acc >= mem unsigned, Z=1 on equality, and N is bit 7 of acc - mem. dec_i and carry_i have no effect.
- R8: Code 13 (AND-then-subtract): the result is (acc AND aux) - mem modulo 256, and C=1 when (acc AND aux) >= mem. It always works in binary, and dec_i and carry_i have no effect.
- R9: Code 6 (bit test): the result is acc, unchanged. N is mem bit 7, V is mem bit 6, and Z=1 when (acc AND mem) is zero.
- R10: Code 7 shifts acc left, filling bit 0 with 0 and moving bit 7 to C. Code 8 shifts acc right, filling bit 7 with 0 and moving bit 0 to C.
- R11: Code 9 rotates acc left, placing carry_i in bit 0 and moving bit 7 to C. Code 10 rotates acc right, placing carry_i in bit 7 and moving bit 0 to C.
- R12: Code 11 gives mem+1 and code 12 gives mem-1, both wrapping modulo 256. Only N and Z are marked.
- R13: `upd_mask_o` is {N,V,Z,C} in bits 3..0. It is 1111 for codes 0-1, 1010 for codes 2-4, 11, 12 and 14, 1011 for codes 5, 7-10 and 13, 1110 for code 6, and 0000 for code 15, which returns acc. Any flag output whose mask bit is clear reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| mem_i | input | 8 | Memory or immediate operand |
| aux_i | input | 8 | Index operand for AND-then-subtract |
| carry_i | input | 1 | Carry input |
| dec_i | input | 1 | Decimal-mode input |
| res_valid_o | output | 1 | Result registers hold a new operation |
| res_o | output | 8 | Result |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| upd_mask_o | output | 4 | Flags to update, {N,V,Z,C} |

## Verification
The hardest cases to reach are the decimal digit adjustments that ripple into the next digit. A low digit that overflows past nine has to carry into a high digit that is itself at nine, and a borrow has to chain through both digits and wrap to 99. These show up only for particular operand pairs. The stimulus therefore sweeps every pair of valid two-digit BCD values with both carry inputs, for add and for subtract. For each pair the expected value is worked out as ordinary decimal arithmetic and then re-encoded. The binary operations run every accumulator value against a spread of memory values, with dec_i toggling, to show that the decimal input is ignored outside add and subtract.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_AND    = 4'd2,
        OP_OR     = 4'd3,
        OP_XOR    = 4'd4,
        OP_CMP    = 4'd5,
        OP_BIT    = 4'd6,
        OP_SHL    = 4'd7,
        OP_SHR    = 4'd8,
        OP_ROL    = 4'd9,
        OP_ROR    = 4'd10,
        OP_INC    = 4'd11,
        OP_DEC    = 4'd12,
        OP_ANDSUB = 4'd13,
        OP_LOAD   = 4'd14,
        OP_NONE   = 4'd15
    } alu_op_e;

    // packed order gives bit3=N .. bit0=C
    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    input  logic          dec_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    localparam int unsigned DIGITS = DW / 4;

    logic [DW-1:0] b_eff;
    logic [DW-1:0] bin_sum;
    logic          bin_cout;
    logic [DW-1:0] dec_sum;
    logic          dec_cout;

    // binary path: subtract is add of the inverted operand
    always_comb begin
        b_eff                 = sub_i ? ~b_i : b_i;
        {bin_cout, bin_sum}   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
        ovf_o = (a_i[DW-1] == b_eff[DW-1]) && (bin_sum[DW-1] != a_i[DW-1]);
    end

    // decimal path: one adjust stage per digit, carry or borrow chained
    always_comb begin
        logic       link;
        logic [4:0] t;
        dec_sum = '0;
        link    = sub_i ? ~cin_i : cin_i;
        t       = '0;
        for (int d = 0; d < DIGITS; d++) begin
            if (sub_i) begin
                t = {1'b0, a_i[4*d +: 4]} - {1'b0, b_i[4*d +: 4]} - {4'b0, link};
                if (t[4]) begin
                    t    = t - 5'd6;
                    link = 1'b1;
                end else begin
                    link = 1'b0;
                end
            end else begin
                t = {1'b0, a_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]} + {4'b0, link};
                if (t > 5'd9) begin
                    t    = t + 5'd6;
                    link = 1'b1;
                end else begin
                    link = 1'b0;
                end
            end
            dec_sum[4*d +: 4] = t[3:0];
        end
        dec_cout = sub_i ? ~link : link;
    end

    assign sum_o  = dec_i ? dec_sum  : bin_sum;
    assign cout_o = dec_i ? dec_cout : bin_cout;

endmodule

// File: rtl/alu8_shift_logic.sv
module alu8_shift_logic
    import alu8_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] m_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    always_comb begin
        res_o  = a_i;
        cout_o = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_i & m_i;
            OP_OR:  res_o = a_i | m_i;
            OP_XOR: res_o = a_i ^ m_i;
            OP_SHL: begin res_o = {a_i[DW-2:0], 1'b0};  cout_o = a_i[DW-1]; end
            OP_SHR: begin res_o = {1'b0, a_i[DW-1:1]};  cout_o = a_i[0];    end
            OP_ROL: begin res_o = {a_i[DW-2:0], cin_i}; cout_o = a_i[DW-1]; end
            OP_ROR: begin res_o = {cin_i, a_i[DW-1:1]}; cout_o = a_i[0];    end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flag_mask.sv
module alu8_flag_mask
    import alu8_pkg::*;
(
    input  alu_op_e op_i,
    output flags_t  mask_o
);
    always_comb begin
        unique case (op_i)
            OP_ADD, OP_SUB:                              mask_o = 4'b1111;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC,
            OP_LOAD:                                     mask_o = 4'b1010;
            OP_CMP, OP_SHL, OP_SHR, OP_ROL, OP_ROR,
            OP_ANDSUB:                                   mask_o = 4'b1011;
            OP_BIT:                                      mask_o = 4'b1110;
            default:                                     mask_o = 4'b0000;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid_i,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] mem_i,
    input  logic [DW-1:0] aux_i,
    input  logic          carry_i,
    input  logic          dec_i,
    output logic          res_valid_o,
    output logic [DW-1:0] res_o,
    output logic          flag_n_o,
    output logic          flag_v_o,
    output logic          flag_z_o,
    output logic          flag_c_o,
    output logic [3:0]    upd_mask_o
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] res;
        flags_t        flg;
        flags_t        mask;
    } out_t;

    out_t    st_d, st_q;
    alu_op_e op;

    logic [DW-1:0] as_a, as_sum, sl_res;
    logic          as_cin, as_sub, as_dec, as_cout, as_ovf, sl_cout;
    flags_t        mask;

    assign op = alu_op_e'(op_i);

    // operand steering for the shared adder
    always_comb begin
        as_a   = (op == OP_ANDSUB) ? (acc_i & aux_i) : acc_i;
        as_sub = (op == OP_SUB) || (op == OP_CMP) || (op == OP_ANDSUB);
        as_cin = (op == OP_CMP || op == OP_ANDSUB) ? 1'b1 : carry_i;
        as_dec = dec_i && (op == OP_ADD || op == OP_SUB);
    end

    alu8_addsub #(.DW(DW)) addsub_i (
        .a_i    (as_a),
        .b_i    (mem_i),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .dec_i  (as_dec),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .ovf_o  (as_ovf)
    );

    alu8_shift_logic #(.DW(DW)) shl_i (
        .op_i   (op),
        .a_i    (acc_i),
        .m_i    (mem_i),
        .cin_i  (carry_i),
        .res_o  (sl_res),
        .cout_o (sl_cout)
    );

    alu8_flag_mask mask_i (
        .op_i   (op),
        .mask_o (mask)
    );

    always_comb begin
        logic [DW-1:0] nz_src;
        flags_t        f;
        st_d       = st_q;
        st_d.valid = in_valid_i;
        f          = '0;
        st_d.res   = acc_i;
        unique case (op)
            OP_ADD, OP_SUB: begin
                st_d.res = as_sum;
                f.c      = as_cout;
                f.v      = as_ovf;
            end
            OP_CMP:    f.c = as_cout;
            OP_ANDSUB: begin
                st_d.res = as_sum;
                f.c      = as_cout;
            end
            OP_BIT:    f.v = mem_i[DW-2];
            OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                st_d.res = sl_res;
                f.c      = sl_cout;
            end
            OP_INC:  st_d.res = mem_i + 1'b1;
            OP_DEC:  st_d.res = mem_i - 1'b1;
            OP_LOAD: st_d.res = mem_i;
            default: ;
        endcase
        nz_src = (op == OP_CMP) ? as_sum : st_d.res;
        f.n    = (op == OP_BIT) ? mem_i[DW-1] : nz_src[DW-1];
        f.z    = (op == OP_BIT) ? ((acc_i & mem_i) == '0) : (nz_src == '0);
        if (in_valid_i) begin
            st_d.mask = mask;
            st_d.flg  = f & mask;
        end else begin
            st_d.res  = st_q.res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.valid;
    assign res_o       = st_q.res;
    assign flag_n_o    = st_q.flg.n;
    assign flag_v_o    = st_q.flg.v;
    assign flag_z_o    = st_q.flg.z;
    assign flag_c_o    = st_q.flg.c;
    assign upd_mask_o  = st_q.mask;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid_i,
    input logic [3:0]    op_i,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] mem_i,
    input logic          carry_i,
    input logic          res_valid_o,
    input logic [DW-1:0] res_o,
    input logic          flag_n_o,
    input logic          flag_v_o,
    input logic          flag_c_o,
    input logic [3:0]    upd_mask_o
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> res_valid_o == $past(in_valid_i));

    // overflow may only be marked by add, subtract or bit test
    p_v_scope_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) && upd_mask_o[2]
        |-> ($past(op_i) == 4'd0 || $past(op_i) == 4'd1 || $past(op_i) == 4'd6));

    p_bit_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) && $past(op_i) == 4'd6
        |-> res_o == $past(acc_i) && flag_n_o == $past(mem_i[DW-1])
            && flag_v_o == $past(mem_i[DW-2]));

    p_cmp_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) && $past(op_i) == 4'd5
        |-> flag_c_o == ($past(acc_i) >= $past(mem_i)) && res_o == $past(acc_i));

    p_shl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) && $past(op_i) == 4'd7
        |-> res_o == {$past(acc_i[DW-2:0]), 1'b0} && flag_c_o == $past(acc_i[DW-1]));

    p_ror_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) && $past(op_i) == 4'd10
        |-> res_o == {$past(carry_i), $past(acc_i[DW-1:1])} && flag_c_o == $past(acc_i[0]));

    p_inc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) && $past(op_i) == 4'd11
        |-> res_o == $past(mem_i) + 1'b1 && !flag_v_o && !flag_c_o);

endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .acc_i       (acc_i),
    .mem_i       (mem_i),
    .carry_i     (carry_i),
    .res_valid_o (res_valid_o),
    .res_o       (res_o),
    .flag_n_o    (flag_n_o),
    .flag_v_o    (flag_v_o),
    .flag_c_o    (flag_c_o),
    .upd_mask_o  (upd_mask_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, mem_i = '0, aux_i = '0;
    logic       carry_i = 1'b0, dec_i = 1'b0;
    logic       res_valid_o;
    logic [7:0] res_o;
    logic       flag_n_o, flag_v_o, flag_z_o, flag_c_o;
    logic [3:0] upd_mask_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
        .acc_i(acc_i), .mem_i(mem_i), .aux_i(aux_i), .carry_i(carry_i),
        .dec_i(dec_i), .res_valid_o(res_valid_o), .res_o(res_o),
        .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o),
        .flag_c_o(flag_c_o), .upd_mask_o(upd_mask_o)
    );

    function automatic int to_dec(int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction

    function automatic int sgn(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // reference: returns {result, N, V, Z, C, mask}
    function automatic logic [15:0] model(int op, int a, int m, int x, int c, int d);
        int r = a, s = 0, sv = 0, nz = 0;
        logic n = 0, v = 0, z = 0, cy = 0, n_set = 0, z_set = 0;
        logic [3:0] mk = 4'b0000;
        case (op)
            0: begin   // R2, R4
                if (d) begin
                    s = to_dec(a) + to_dec(m) + c; cy = (s >= 100); s = s % 100;
                    r = (s / 10) * 16 + s % 10;
                end else begin
                    s = a + m + c; cy = (s > 255); r = s & 255;
                end
                sv = sgn(a) + sgn(m) + c; v = (sv > 127 || sv < -128); mk = 4'b1111;
            end
            1: begin   // R3, R5
                if (d) begin
                    s = to_dec(a) - to_dec(m) - (1 - c); cy = (s >= 0);
                    if (s < 0) s = s + 100;
                    r = (s / 10) * 16 + s % 10;
                end else begin
                    s = a - m - (1 - c); cy = (s >= 0); r = s & 255;
                end
                sv = sgn(a) - sgn(m) - (1 - c); v = (sv > 127 || sv < -128); mk = 4'b1111;
            end
            2:  begin r = a & m; mk = 4'b1010; end   // R6
            3:  begin r = a | m; mk = 4'b1010; end
            4:  begin r = a ^ m; mk = 4'b1010; end
            14: begin r = m;     mk = 4'b1010; end
            5: begin   // R7
                r = a; cy = (a >= m); nz = (a - m) & 255;
                n = nz[7]; z = (nz == 0); n_set = 1; z_set = 1; mk = 4'b1011;
            end
            6: begin   // R9
                r = a; n = m[7]; v = m[6]; z = ((a & m) == 0);
                n_set = 1; z_set = 1; mk = 4'b1110;
            end
            7:  begin r = (a << 1) & 255;       cy = a[7]; mk = 4'b1011; end  // R10
            8:  begin r = a >> 1;               cy = a[0]; mk = 4'b1011; end
            9:  begin r = ((a << 1) | c) & 255; cy = a[7]; mk = 4'b1011; end  // R11
            10: begin r = (a >> 1) | (c << 7);  cy = a[0]; mk = 4'b1011; end
            11: begin r = (m + 1) & 255;   mk = 4'b1010; end   // R12
            12: begin r = (m + 255) & 255; mk = 4'b1010; end
            13: begin   // R8
                s = (a & x) - m; r = s & 255; cy = ((a & x) >= m); mk = 4'b1011;
            end
            default: begin r = a; mk = 4'b0000; end   // R13
        endcase
        if (!n_set) n = r[7];
        if (!z_set) z = (r == 0);
        return {r[7:0], n & mk[3], v & mk[2], z & mk[1], cy & mk[0], mk};
    endfunction

    function automatic string req_of(int op, int d);
        case (op)
            0: return d ? "R4" : "R2";
            1: return d ? "R5" : "R3";
            2, 3, 4, 14: return "R6";
            5: return "R7";
            6: return "R9";
            7, 8: return "R10";
            9, 10: return "R11";
            11, 12: return "R12";
            13: return "R8";
            default: return "R13";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at negedge, sample registered outputs one cycle later at negedge
    task automatic run(int op, int a, int m, int x, int c, int d);
        logic [15:0] e;
        logic [15:0] got;
        op_i = op[3:0]; acc_i = a[7:0]; mem_i = m[7:0]; aux_i = x[7:0];
        carry_i = c[0]; dec_i = d[0]; in_valid_i = 1'b1;
        @(negedge clk);
        e   = model(op, a, m, x, c, d);
        got = {res_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o, upd_mask_o};
        check(got == e && res_valid_o, req_of(op, d),
              $sformatf("op=%0d a=%h m=%h x=%h c=%0d d=%0d {res,nvzc,mask}", op, a, m, x, c, d),
              got, e);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({res_valid_o, res_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o, upd_mask_o} == 0,
              "R1", "reset outputs", {res_valid_o, res_o, upd_mask_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid_o == 1'b0, "R1", "valid idle", res_valid_o, 0);

        // R2 named overflow cases
        run(0, 8'h7F, 8'h01, 0, 0, 0);
        check(flag_v_o == 1'b1, "R2", "0x7F+0x01 V", flag_v_o, 1);
        run(0, 8'h81, 8'hFF, 0, 0, 0);
        check(flag_v_o == 1'b0, "R2", "0x81+0xFF V", flag_v_o, 0);
        // R4, R5 digit-chain corners
        run(0, 8'h99, 8'h01, 0, 0, 1);
        check(res_o == 8'h00 && flag_c_o, "R4", "99+01 dec", res_o, 0);
        run(1, 8'h00, 8'h01, 0, 1, 1);
        check(res_o == 8'h99 && !flag_c_o, "R5", "00-01 dec", res_o, 8'h99);

        // R1: hold while idle
        in_valid_i = 1'b0;
        @(negedge clk);
        check(res_valid_o == 1'b0 && res_o == 8'h99, "R1", "hold when idle", res_o, 8'h99);

        // sweep every code: all acc values, spread of mem values, both carries
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 8; k++)
                    for (int c = 0; c < 2; c++) begin
                        int m = (k == 7) ? 255 : k * 37;
                        int d = (op <= 1) ? 0 : ((a ^ k) & 1);
                        run(op, a, m, a ^ 8'h5A, c, d);
                    end

        // full decimal sweep over valid BCD operands (R4, R5)
        for (int op = 0; op < 2; op++)
            for (int da = 0; da < 100; da++)
                for (int db = 0; db < 100; db++)
                    for (int c = 0; c < 2; c++)
                        run(op, (da / 10) * 16 + da % 10, (db / 10) * 16 + db % 10, 0, c, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule